// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one compare channel of a multi-channel event timer. A shared free-running main counter, kept outside the block, is fed in on every clock. The channel holds a comparator value and a reload period. It raises a single-cycle interrupt pulse when the counter arrives at or steps past the comparator. In one-shot mode the channel fires once per match. In periodic mode it also moves the comparator forward by the period until the comparator is ahead of the counter again.

Compares run at one of two widths. In wide mode the full counter is used. In narrow mode only the lower half of the counter is used, and the upper halves of the comparator and period are cleared. A narrow one-shot channel also pulses when the lower half of the counter rolls over to zero.

Software writes the comparator a half-word at a time. A self-clearing set-value flag decides whether a write in periodic mode lands in the comparator or only in the period. Routing of the interrupt, address decode and the counter itself belong to neighbouring blocks.

Top module: `evt_cmp_channel`

## Requirements
- R1: After a synchronous reset the comparator reads all ones, the period reads 0, the set-value flag reads 0, the interrupt is low. The capability output reads 2'b11: bit 0 is periodic-capable and bit 1 is wide-capable.
- R2: In one-shot mode, irq_o is high for exactly one cycle. It rises on the cycle after the clock edge at which count_i first stands at or past the comparator, having been before it at the previous edge. A count that jumps over the exact value still fires once. The pulse does not repeat while the count stays past.
- R3: In periodic mode with a nonzero period, a match adds the period to the comparator once per clock until the comparator is ahead of the count. Only one pulse is given for the whole catch-up. "Ahead" means the wrapped difference at the active width is positive. With a period of 0, periodic mode behaves like one-shot.
- R4: A write to either comparator half goes into the comparator when the channel is one-shot or the set-value flag is 1. In periodic mode, a low-half write always also loads the low half of the period. In periodic mode with set-value 0, a high-half write loads only the high half of the period.
- R5: arm_setval_i sets the set-value flag. Any comparator write, low or high, clears it, and a write wins over an arm in the same cycle.
- R6: The most significant bit of any value loaded into the period is forced to 0. That is bit 63 for a high-half write, and bit 31 for a low-half write in narrow mode.
- R7: While narrow_i is 1, the upper halves of the comparator and period read 0 from the next cycle on. Matches use only the low 32 bits of the count, whatever its upper bits hold.
- R8: In narrow one-shot mode, an extra pulse is given when the low 32 bits of the count go from 32'hFFFFFFFF to 32'h0, in addition to the match pulse.
- R9: A pulse appears only when ch_en_i and glb_en_i were both 1 at the triggering edge. With glb_en_i at 0 there is no match detection and no periodic advance. With ch_en_i at 0, matches and advances still happen but produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | CNT_W | Shared main counter value |
| glb_en_i | input | 1 | Global enable of the timer |
| ch_en_i | input | 1 | Interrupt enable of this channel |
| periodic_i | input | 1 | 1 selects periodic mode, 0 one-shot |
| narrow_i | input | 1 | 1 selects half-width (32-bit) compares |
| arm_setval_i | input | 1 | Strobe that sets the set-value flag |
| wr_lo_i | input | 1 | Write strobe, low comparator half |
| wr_hi_i | input | 1 | Write strobe, high comparator half |
| wdata_i | input | CNT_W/2 | Write data for either half |
| cmp_o | output | CNT_W | Comparator readback |
| period_o | output | CNT_W | Period readback |
| setval_o | output | 1 | Current set-value flag |
| caps_o | output | 2 | Capability bits: [0] periodic, [1] wide |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the channel with CNT_W = 64, so the halves are 32 bits wide. Narrow and wide compares, both period MSB positions and the lower-half rollover at 32'hFFFFFFFF can then all be reached within a few hundred clocks. Because the counter is a plain input, the bench places it next to a rollover or makes it jump over the comparator or several periods at once. This drives the skip-over match, the multi-cycle periodic catch-up and the wrap pulse without long runs.

// File: rtl/evt_cmp_pkg.sv
// Shared constants for the event timer comparator channel.
// Assumes nothing beyond the parameters of the instantiating block.
package evt_cmp_pkg;
    // Bit positions in the capability output
    localparam int unsigned CAP_PERIODIC_BIT = 0;
    localparam int unsigned CAP_WIDE_BIT     = 1;
    localparam int unsigned CAP_W            = 2;

    // Order comparisons performed every cycle
    localparam int unsigned ORD_PREV_CMP = 0;  // previous count vs comparator
    localparam int unsigned ORD_CNT_CMP  = 1;  // current count vs comparator
    localparam int unsigned ORD_CNT_NEXT = 2;  // current count vs comparator + period
    localparam int unsigned ORD_NUM      = 3;
endpackage

// File: rtl/evt_cmp_order.sv
// Wrapped order test: before_o is 1 when a_i lies strictly before c_i,
// judged by the sign of (c_i - a_i) at the active width. In narrow mode
// only the lower halves take part.
// Assumes CNT_W is even.
module evt_cmp_order #(
    parameter int unsigned CNT_W = 64,
    localparam int unsigned HALF_W = CNT_W / 2
) (
    input  logic             narrow_i,
    input  logic [CNT_W-1:0] a_i,
    input  logic [CNT_W-1:0] c_i,
    output logic             before_o
);
    logic [CNT_W-1:0]  diff_wide;
    logic [HALF_W-1:0] diff_half;

    // Positive wrapped difference means a is before c
    always_comb begin
        diff_wide = c_i - a_i;
        diff_half = c_i[HALF_W-1:0] - a_i[HALF_W-1:0];
        if (narrow_i) begin
            before_o = !diff_half[HALF_W-1] && (|diff_half);
        end else begin
            before_o = !diff_wide[CNT_W-1] && (|diff_wide);
        end
    end
endmodule

// File: rtl/evt_cmp_regs.sv
// Comparator, period and set-value flag storage with the write rules.
// A periodic advance is applied first, then software writes override
// their half, then narrow mode clears the upper halves.
// Assumes wr_lo_i and wr_hi_i may be high together; each handles its half.
module evt_cmp_regs #(
    parameter int unsigned CNT_W = 64,
    localparam int unsigned HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              narrow_i,
    input  logic              periodic_i,
    input  logic              arm_setval_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [HALF_W-1:0] wdata_i,
    input  logic              adv_i,
    input  logic [CNT_W-1:0]  cmp_adv_i,
    output logic [CNT_W-1:0]  cmp_q,
    output logic [CNT_W-1:0]  per_q,
    output logic              sv_q
);
    logic [CNT_W-1:0] cmp_d;
    logic [CNT_W-1:0] per_d;
    logic             sv_d;
    logic             to_cmp;

    // Next-state of comparator, period and set-value flag
    always_comb begin
        cmp_d  = cmp_q;
        per_d  = per_q;
        sv_d   = sv_q;
        to_cmp = !periodic_i || sv_q;
        if (adv_i) begin
            cmp_d = cmp_adv_i;
        end
        if (wr_lo_i) begin
            if (to_cmp) begin
                cmp_d[HALF_W-1:0] = wdata_i;
            end
            if (periodic_i) begin
                per_d[HALF_W-1:0] = wdata_i;
                if (narrow_i) begin
                    per_d[HALF_W-1] = 1'b0;
                end
            end
        end
        if (wr_hi_i) begin
            if (to_cmp) begin
                cmp_d[CNT_W-1:HALF_W] = wdata_i;
            end else begin
                per_d[CNT_W-1:HALF_W] = wdata_i;
                per_d[CNT_W-1]        = 1'b0;
            end
        end
        if (wr_lo_i || wr_hi_i) begin
            sv_d = 1'b0;
        end else if (arm_setval_i) begin
            sv_d = 1'b1;
        end
        if (narrow_i) begin
            cmp_d[CNT_W-1:HALF_W] = '0;
            per_d[CNT_W-1:HALF_W] = '0;
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '1;
            per_q <= '0;
            sv_q  <= 1'b0;
        end else begin
            cmp_q <= cmp_d;
            per_q <= per_d;
            sv_q  <= sv_d;
        end
    end
endmodule

// File: rtl/evt_cmp_fire.sv
// Match, wrap and catch-up control. It keeps the previous count, flags a
// periodic catch-up that is still behind, and registers the pulse.
// Assumes the order flags come from evt_cmp_order instances that see
// prev_o, count_i, the comparator and comparator + period.
module evt_cmp_fire #(
    parameter int unsigned CNT_W = 64,
    localparam int unsigned HALF_W = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic             glb_en_i,
    input  logic             ch_en_i,
    input  logic             periodic_i,
    input  logic             narrow_i,
    input  logic             per_nz_i,
    input  logic             prev_before_i,
    input  logic             cnt_before_i,
    input  logic             next_before_i,
    output logic [CNT_W-1:0] prev_o,
    output logic             adv_o,
    output logic             irq_o
);
    logic catch_q;
    logic reached;
    logic match;
    logic wrap;

    // Combinational match, wrap and advance decisions
    always_comb begin
        reached = !cnt_before_i;
        adv_o   = glb_en_i && periodic_i && per_nz_i && reached;
        match   = glb_en_i && prev_before_i && reached && !catch_q;
        wrap    = glb_en_i && narrow_i && !periodic_i
                  && (&prev_o[HALF_W-1:0]) && !(|count_i[HALF_W-1:0]);
    end

    // History, catch-up flag and pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_o  <= '0;
            catch_q <= 1'b0;
            irq_o   <= 1'b0;
        end else begin
            prev_o  <= count_i;
            catch_q <= adv_o && !next_before_i;
            irq_o   <= ch_en_i && (match || wrap);
        end
    end
endmodule

// File: rtl/evt_cmp_channel.sv
// One comparator channel of an event timer. It watches the shared main
// counter and pulses irq_o on a match (one-shot or periodic) and, in
// narrow one-shot mode, on a lower-half rollover.
// Assumes count_i is driven by the timer's main counter every clock.
module evt_cmp_channel
    import evt_cmp_pkg::*;
#(
    parameter int unsigned CNT_W = 64,
    parameter bit PERIODIC_CAP = 1'b1,
    parameter bit WIDE_CAP     = 1'b1,
    localparam int unsigned HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              glb_en_i,
    input  logic              ch_en_i,
    input  logic              periodic_i,
    input  logic              narrow_i,
    input  logic              arm_setval_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [HALF_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  cmp_o,
    output logic [CNT_W-1:0]  period_o,
    output logic              setval_o,
    output logic [CAP_W-1:0]  caps_o,
    output logic              irq_o
);
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] prev_q;
    logic [CNT_W-1:0] cmp_next;
    logic             adv;
    logic [CNT_W-1:0] ord_a [ORD_NUM];
    logic [CNT_W-1:0] ord_c [ORD_NUM];
    logic [ORD_NUM-1:0] ord_before;

    // Candidate comparator after one periodic step
    assign cmp_next = cmp_q + per_q;

    // Operands of the three order tests
    always_comb begin
        ord_a[ORD_PREV_CMP] = prev_q;
        ord_c[ORD_PREV_CMP] = cmp_q;
        ord_a[ORD_CNT_CMP]  = count_i;
        ord_c[ORD_CNT_CMP]  = cmp_q;
        ord_a[ORD_CNT_NEXT] = count_i;
        ord_c[ORD_CNT_NEXT] = cmp_next;
    end

    for (genvar g = 0; g < ORD_NUM; g++) begin : g_ord
        evt_cmp_order #(.CNT_W(CNT_W)) u_ord (
            .narrow_i (narrow_i),
            .a_i      (ord_a[g]),
            .c_i      (ord_c[g]),
            .before_o (ord_before[g])
        );
    end

    evt_cmp_regs #(.CNT_W(CNT_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .narrow_i     (narrow_i),
        .periodic_i   (periodic_i),
        .arm_setval_i (arm_setval_i),
        .wr_lo_i      (wr_lo_i),
        .wr_hi_i      (wr_hi_i),
        .wdata_i      (wdata_i),
        .adv_i        (adv),
        .cmp_adv_i    (cmp_next),
        .cmp_q        (cmp_q),
        .per_q        (per_q),
        .sv_q         (setval_o)
    );

    evt_cmp_fire #(.CNT_W(CNT_W)) u_fire (
        .clk           (clk),
        .rst_n         (rst_n),
        .count_i       (count_i),
        .glb_en_i      (glb_en_i),
        .ch_en_i       (ch_en_i),
        .periodic_i    (periodic_i),
        .narrow_i      (narrow_i),
        .per_nz_i      (|per_q),
        .prev_before_i (ord_before[ORD_PREV_CMP]),
        .cnt_before_i  (ord_before[ORD_CNT_CMP]),
        .next_before_i (ord_before[ORD_CNT_NEXT]),
        .prev_o        (prev_q),
        .adv_o         (adv),
        .irq_o         (irq_o)
    );

    // Readback and fixed capabilities
    always_comb begin
        cmp_o                    = cmp_q;
        period_o                 = per_q;
        caps_o                   = '0;
        caps_o[CAP_PERIODIC_BIT] = PERIODIC_CAP;
        caps_o[CAP_WIDE_BIT]     = WIDE_CAP;
    end
endmodule

// File: rtl/evt_cmp_channel_chk.sv
// Temporal checks on the comparator channel ports, bound to the top.
// Assumes the synchronous active-low reset of the channel.
module evt_cmp_channel_chk #(
    parameter int unsigned CNT_W = 64,
    localparam int unsigned HALF_W = CNT_W / 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_i,
    input logic             glb_en_i,
    input logic             ch_en_i,
    input logic             periodic_i,
    input logic             narrow_i,
    input logic             wr_lo_i,
    input logic             wr_hi_i,
    input logic [CNT_W-1:0] cmp_o,
    input logic [CNT_W-1:0] period_o,
    input logic             setval_o,
    input logic             irq_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) == 1'b0) |-> (cmp_o == '1 && period_o == '0 && !setval_o && !irq_o));

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && irq_o) |-> $past(ch_en_i && glb_en_i));

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!glb_en_i && !wr_lo_i && !wr_hi_i && !narrow_i)) |-> $stable(cmp_o));

    // R5
    setval_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_lo_i || wr_hi_i)) |-> !setval_o);

    // R6
    period_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_o[CNT_W-1] == 1'b0);

    // R7
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(narrow_i)) |-> (cmp_o[CNT_W-1:HALF_W] == '0 && period_o[CNT_W-1:HALF_W] == '0));

    // R8
    wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(glb_en_i && ch_en_i && narrow_i && !periodic_i)
         && $past(count_i[HALF_W-1:0]) == '0 && $past(count_i[HALF_W-1:0], 2) == '1) |-> irq_o);
endmodule

bind evt_cmp_channel evt_cmp_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_i    (count_i),
    .glb_en_i   (glb_en_i),
    .ch_en_i    (ch_en_i),
    .periodic_i (periodic_i),
    .narrow_i   (narrow_i),
    .wr_lo_i    (wr_lo_i),
    .wr_hi_i    (wr_hi_i),
    .cmp_o      (cmp_o),
    .period_o   (period_o),
    .setval_o   (setval_o),
    .irq_o      (irq_o)
);

// File: tb/evt_cmp_channel_tb.sv
`timescale 1ns/1ps
module evt_cmp_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt = '0;
    logic        glb = 1'b0, chen = 1'b0, per = 1'b0, nar = 1'b0;
    logic        arm = 1'b0, wlo = 1'b0, whi = 1'b0;
    logic [31:0] wd = '0;
    logic [63:0] cmp_o, period_o;
    logic        setval_o, irq_o;
    logic [1:0]  caps_o;

    int    n_chk = 0, n_bad = 0, pulses = 0, cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    logic [63:0] m_cmp, m_per, m_prev;
    logic        m_sv, m_catch, m_irq;

    always #2 clk = ~clk;

    evt_cmp_channel u_dut (
        .clk(clk), .rst_n(rst_n), .count_i(cnt), .glb_en_i(glb), .ch_en_i(chen),
        .periodic_i(per), .narrow_i(nar), .arm_setval_i(arm), .wr_lo_i(wlo),
        .wr_hi_i(whi), .wdata_i(wd), .cmp_o(cmp_o), .period_o(period_o),
        .setval_o(setval_o), .caps_o(caps_o), .irq_o(irq_o)
    );

    function automatic bit ahead(bit narrow, logic [63:0] a, logic [63:0] c);
        int     d32;
        longint d64;
        d32 = int'(c[31:0] - a[31:0]);
        d64 = longint'(c - a);
        return narrow ? (d32 > 0) : (d64 > 0);
    endfunction

    // behavioural reference, one step per clock
    always @(posedge clk) begin
        bit reached, adv;
        logic [63:0] sum;
        if (!rst_n) begin
            m_cmp = '1; m_per = '0; m_sv = 0; m_prev = '0; m_catch = 0; m_irq = 0;
        end else begin
            reached = !ahead(nar, cnt, m_cmp);
            m_irq = chen && glb && ((ahead(nar, m_prev, m_cmp) && reached && !m_catch)
                    || (nar && !per && m_prev[31:0] == 32'hFFFF_FFFF && cnt[31:0] == 32'h0));
            adv = glb && per && (m_per != 0) && reached;
            sum = m_cmp + m_per;
            m_catch = adv && !ahead(nar, cnt, sum);
            if (adv) m_cmp = sum;
            if (wlo) begin
                if (!per || m_sv) m_cmp[31:0] = wd;
                if (per) begin m_per[31:0] = wd; if (nar) m_per[31] = 1'b0; end
            end
            if (whi) begin
                if (!per || m_sv) m_cmp[63:32] = wd;
                else begin m_per[63:32] = wd; m_per[63] = 1'b0; end
            end
            if (wlo || whi) m_sv = 0; else if (arm) m_sv = 1;
            if (nar) begin m_cmp[63:32] = '0; m_per[63:32] = '0; end
            m_prev = cnt;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compare with the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq_o === m_irq, {cur_req, " irq"}, {63'd0, irq_o}, {63'd0, m_irq});
            chk(cmp_o === m_cmp, {cur_req, " cmp"}, cmp_o, m_cmp);
            chk(period_o === m_per, {cur_req, " period"}, period_o, m_per);
            chk(setval_o === m_sv, {cur_req, " setval"}, {63'd0, setval_o}, {63'd0, m_sv});
            if (irq_o) pulses++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic tick(); @(negedge clk); #1; endtask
    task automatic step(input int n, input int inc);
        for (int i = 0; i < n; i++) begin cnt = cnt + 64'(inc); tick(); end
    endtask
    task automatic wr_lo(input logic [31:0] v); wlo = 1; wd = v; tick(); wlo = 0; endtask
    task automatic wr_hi(input logic [31:0] v); whi = 1; wd = v; tick(); whi = 0; endtask
    task automatic arm_sv(); arm = 1; tick(); arm = 0; endtask

    initial begin
        int p0;
        repeat (3) tick();
        rst_n = 1; tick();
        // R1 reset state
        chk(cmp_o == '1, "R1 cmp", cmp_o, '1);
        chk(period_o == '0, "R1 period", period_o, '0);
        chk(!setval_o && !irq_o, "R1 flags", {62'd0, setval_o, irq_o}, '0);
        chk(caps_o == 2'b11, "R1 caps", {62'd0, caps_o}, 64'd3);

        // R2 one-shot, exact hit then skip-over
        cur_req = "R2"; glb = 1; chen = 1;
        wr_lo(32'd100); wr_hi(32'd0);
        p0 = pulses; step(150, 1); tick();
        chk(pulses - p0 == 1, "R2 exact", 64'(pulses - p0), 64'd1);
        wr_lo(32'd500);
        p0 = pulses; step(20, 30); tick();
        chk(pulses - p0 == 1, "R2 skip", 64'(pulses - p0), 64'd1);

        // R9 channel and global gating
        cur_req = "R9"; chen = 0; cnt = 0; tick(); wr_lo(32'd40);
        p0 = pulses; step(60, 1); tick();
        chk(pulses == p0, "R9 ch_en off", 64'(pulses - p0), 64'd0);
        glb = 0; chen = 1; cnt = 0; tick();
        p0 = pulses; step(60, 1); tick();
        chk(pulses == p0, "R9 glb off", 64'(pulses - p0), 64'd0);
        glb = 1; tick();

        // R3/R4/R5 periodic behaviour
        cur_req = "R3"; cnt = 64'd1000; per = 1; tick();
        arm_sv(); chk(setval_o, "R5 arm", {63'd0, setval_o}, 64'd1);
        wr_lo(32'd1020);
        chk(cmp_o == 64'd1020 && period_o == 64'd1020, "R4 lo setval", cmp_o, 64'd1020);
        chk(!setval_o, "R5 cleared", {63'd0, setval_o}, 64'd0);
        wr_lo(32'd10);
        chk(cmp_o == 64'd1020 && period_o == 64'd10, "R4 lo period only", period_o, 64'd10);
        p0 = pulses; step(59, 1); tick();
        chk(pulses - p0 == 4, "R3 four periods", 64'(pulses - p0), 64'd4);
        chk(cmp_o == 64'd1060, "R3 cmp advanced", cmp_o, 64'd1060);
        p0 = pulses; cnt = 64'd1100; repeat (8) tick();
        chk(pulses - p0 == 1, "R3 catch-up single pulse", 64'(pulses - p0), 64'd1);
        chk(cmp_o == 64'd1110, "R3 catch-up cmp", cmp_o, 64'd1110);

        cur_req = "R6"; wr_hi(32'hFFFF_FFFF);
        chk(period_o == 64'h7FFF_FFFF_0000_000A, "R6 wide msb", period_o, 64'h7FFF_FFFF_0000_000A);
        chk(cmp_o == 64'd1110, "R4 hi goes to period", cmp_o, 64'd1110);
        cur_req = "R5"; arm = 1; wr_hi(32'd0); arm = 0;
        chk(!setval_o, "R5 write beats arm", {63'd0, setval_o}, 64'd0);
        chk(period_o == 64'd10, "R4 hi period restore", period_o, 64'd10);
        arm_sv(); wr_lo(32'd1200);
        chk(cmp_o == 64'd1200 && period_o == 64'd1200, "R4 lo loads both", cmp_o, 64'd1200);
        wr_hi(32'd3);
        chk(period_o == 64'h3_0000_04B0, "R4 hi period", period_o, 64'h3_0000_04B0);
        per = 0; tick(); wr_hi(32'd5);
        chk(cmp_o == 64'h5_0000_04B0, "R4 one-shot hi", cmp_o, 64'h5_0000_04B0);

        // R7/R8 narrow mode
        cur_req = "R7"; nar = 1; tick();
        chk(cmp_o == 64'h4B0 && period_o == 64'h4B0, "R7 truncate", cmp_o, 64'h4B0);
        cur_req = "R8"; cnt = 64'h5_FFFF_FFF0; tick();
        p0 = pulses; step(40, 1); tick();
        chk(pulses - p0 == 1, "R8 wrap pulse", 64'(pulses - p0), 64'd1);
        cur_req = "R7"; cnt = 64'h6_0000_0490; tick();
        p0 = pulses; step(40, 1); tick();
        chk(pulses - p0 == 1, "R7 low-half match", 64'(pulses - p0), 64'd1);
        cur_req = "R6"; per = 1; tick(); wr_lo(32'hFFFF_FFFF);
        chk(period_o == 64'h7FFF_FFFF, "R6 narrow msb", period_o, 64'h7FFF_FFFF);
        repeat (4) tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule